// File: doc/BRIEF.md
# Displaced Pointer Store Unit

This block carries out one kind of store. A 16-bit register is written to memory at an address formed from a 32-bit pointer register plus a signed 8-bit offset. An instruction arrives as three bytes on a valid/ready input: a prefix byte, a selector byte and the offset byte.

The selector byte picks one of four pointer registers and one of four source registers. The block reads both through combinational read ports outside the block. It adds the sign-extended offset to the pointer and decides whether the result is a logical address or a physical one. It then issues one or two writes on a valid/ready memory write port. A logical address is passed out unchanged, with a flag for an external translator. A `done` pulse marks the end of the instruction's fixed cycle budget.

The instruction port stalls the sender: `ins_ready` is high only while the unit is idle. The write port is stalled by the memory. While `wr_ready` is low, the current beat is held unchanged, and `done` waits for the last beat to complete.

Top module: `ptr_store_unit`

## Requirements
- R1: An instruction is legal only when `ins_op0` is 8'h6D and `ins_op1[3:0]` is 4'h1. `ptr_sel` equals `ins_op1[5:4]`, and `src_sel` equals `ins_op1[7:6]` (0 = BC, 1 = DE, 2 = IX, 3 = IY).
- R2: The effective address is `ptr_data` plus `ins_disp` sign-extended to 32 bits, computed modulo 2^32.
- R3: The low byte of the source is stored at the effective address and the high byte at the effective address plus one. In a two-beat store the low byte goes out first.
- R4: An address whose bits 31:16 are all ones is logical. It is issued unmasked with `wr_logical`=1. The first byte's classification applies to both beats, even when the second address wraps.
- R5: A physical address is issued with `wr_logical`=0 and only its low 20 bits kept. When `cfg_phys24`=1, the low 24 bits are kept instead.
- R6: With `cfg_mode_b`=1 and `cfg_wide_bus`=1, an even address gives one write beat: `wr_be`=2'b11 and `wr_data` equal to the source.
- R7: An odd address, or a narrow bus, gives two byte beats. Each beat has `wr_be`=2'b01 and the byte in `wr_data[7:0]`, with upper bits zero. The second address is the first address plus one, with full 32-bit carry, masked as in R5 when physical. Mode A (`cfg_mode_b`=0) always behaves as a narrow bus.
- R8: The cycle budget is 13 in mode A. In mode B it is 14 for a narrow bus, 13 for a wide bus at an odd address, and 12 for a wide bus at an even address. With no write stall, `done` is high in the budget-th cycle after the accepting edge.
- R9: An illegal instruction is accepted and gives a one-cycle `illegal` pulse in the cycle after acceptance. It produces no write and no `done`, and leaves the unit ready.
- R10: `ins_ready` is low from the cycle after a legal acceptance until the cycle after `done`. `done` lasts exactly one cycle.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_addr`, `wr_data` and `wr_be` hold steady. `done` is not raised before the last beat's handshake, and it may coincide with that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_b | input | 1 | Timing mode B select; sampled at acceptance |
| cfg_wide_bus | input | 1 | 16-bit memory bus in mode B; sampled at acceptance |
| cfg_phys24 | input | 1 | Keep 24 instead of 20 physical address bits |
| ins_valid | input | 1 | Instruction bytes are valid |
| ins_ready | output | 1 | Unit idle, instruction accepted this cycle if valid |
| ins_op0 | input | 8 | Prefix opcode byte |
| ins_op1 | input | 8 | Selector opcode byte |
| ins_disp | input | 8 | Signed displacement |
| ptr_sel | output | 2 | Pointer register read index |
| ptr_data | input | 32 | Pointer register read data |
| src_sel | output | 2 | Source register read index |
| src_data | input | 16 | Source register read data |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | 32 | Write address |
| wr_data | output | 16 | Write data |
| wr_be | output | 2 | Byte enables |
| wr_logical | output | 1 | Address needs translation |
| done | output | 1 | Instruction complete pulse |
| illegal | output | 1 | Illegal opcode pulse |

## Verification
The end of the cycle budget and the handshake of the final write beat can land in the same cycle. The bench provokes this by holding `wr_ready` low well past the budget of a single-word store and then releasing it. It then expects `done` exactly in the cycle of that handshake, neither earlier nor later. Without a stall, the same check expects `done` at the budget cycle, after both beats have drained long before.

// File: rtl/psu_pkg.sv
package psu_pkg;
  localparam logic [7:0] PSU_PREFIX  = 8'h6D;
  localparam logic [3:0] PSU_LOW_NIB = 4'h1;

  typedef enum logic [1:0] {
    SRC_BC = 2'd0,
    SRC_DE = 2'd1,
    SRC_IX = 2'd2,
    SRC_IY = 2'd3
  } src_reg_e;

  typedef struct packed {
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic        logical;
    logic        odd;
  } agen_t;
endpackage

// File: rtl/psu_decode.sv
module psu_decode
  import psu_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op0,
  input  logic [OP_W-1:0] op1,
  output logic [1:0]      ptr_sel,
  output src_reg_e        src_sel,
  output logic            legal
);
  // R1: selector byte fields
  always_comb begin
    ptr_sel = op1[5:4];
    src_sel = src_reg_e'(op1[7:6]);
    legal   = (op0 == PSU_PREFIX) && (op1[3:0] == PSU_LOW_NIB);
  end
endmodule

// File: rtl/psu_agen.sv
module psu_agen
  import psu_pkg::*;
#(
  parameter int PTR_W       = 32,
  parameter int DISP_W      = 8,
  parameter int TAG_W       = 16,
  parameter int PHYS_NARROW = 20,
  parameter int PHYS_WIDE   = 24
) (
  input  logic [PTR_W-1:0]  ptr,
  input  logic [DISP_W-1:0] disp,
  input  logic              phys24,
  output agen_t             res
);
  localparam logic [PTR_W-1:0] MASK_N = {{(PTR_W-PHYS_NARROW){1'b0}}, {PHYS_NARROW{1'b1}}};
  localparam logic [PTR_W-1:0] MASK_W = {{(PTR_W-PHYS_WIDE){1'b0}}, {PHYS_WIDE{1'b1}}};

  logic [PTR_W-1:0] sum0, sum1, mask;
  logic             is_log;

  always_comb begin
    sum0   = ptr + {{(PTR_W-DISP_W){disp[DISP_W-1]}}, disp};       // R2
    sum1   = sum0 + {{(PTR_W-1){1'b0}}, 1'b1};                      // R7 full carry
    is_log = &sum0[PTR_W-1:PTR_W-TAG_W];                            // R4
    mask   = phys24 ? MASK_W : MASK_N;                              // R5
    res.addr_lo = is_log ? sum0 : (sum0 & mask);
    res.addr_hi = is_log ? sum1 : (sum1 & mask);
    res.logical = is_log;
    res.odd     = sum0[0];
  end
endmodule

// File: rtl/psu_wr_seq.sv
module psu_wr_seq #(
  parameter int PTR_W = 32,
  parameter int REG_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PTR_W-1:0] addr_lo,
  input  logic [PTR_W-1:0] addr_hi,
  input  logic             logical,
  input  logic             single,
  input  logic [REG_W-1:0] src,
  input  logic [CNT_W-1:0] cost,
  output logic             busy,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [PTR_W-1:0] wr_addr,
  output logic [REG_W-1:0] wr_data,
  output logic [1:0]       wr_be,
  output logic             wr_logical,
  output logic             done
);
  localparam int BYTE_W = REG_W / 2;

  logic [PTR_W-1:0] a_lo_q, a_hi_q;
  logic [REG_W-1:0] src_q;
  logic [CNT_W-1:0] cnt_q, cost_q;
  logic             log_q, single_q, beat_q, wdone_q;
  logic             fire, last_fire, reached;

  always_comb begin
    wr_valid   = busy && !wdone_q;
    wr_addr    = beat_q ? a_hi_q : a_lo_q;
    wr_logical = log_q;
    if (single_q) begin
      wr_data = src_q;
      wr_be   = 2'b11;
    end else begin
      wr_data = {{BYTE_W{1'b0}}, (beat_q ? src_q[REG_W-1:BYTE_W] : src_q[BYTE_W-1:0])};
      wr_be   = 2'b01;
    end
    fire      = wr_valid && wr_ready;
    last_fire = fire && (single_q || beat_q);
    reached   = (cnt_q >= cost_q);
    done      = busy && reached && (wdone_q || last_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      cost_q   <= '0;
      a_lo_q   <= '0;
      a_hi_q   <= '0;
      src_q    <= '0;
      log_q    <= 1'b0;
      single_q <= 1'b0;
      beat_q   <= 1'b0;
      wdone_q  <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt_q    <= {{(CNT_W-1){1'b0}}, 1'b1};
      cost_q   <= cost;
      a_lo_q   <= addr_lo;
      a_hi_q   <= addr_hi;
      src_q    <= src;
      log_q    <= logical;
      single_q <= single;
      beat_q   <= 1'b0;
      wdone_q  <= 1'b0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      if (!reached) cnt_q <= cnt_q + 1'b1;
      if (fire) begin
        if (last_fire) wdone_q <= 1'b1;
        else           beat_q  <= 1'b1;
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_be_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_be == 2'b01) |-> (wr_data[REG_W-1:BYTE_W] == '0));

  p_done_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done);
endmodule

// File: rtl/ptr_store_unit.sv
module ptr_store_unit
  import psu_pkg::*;
#(
  parameter int PTR_W         = 32,
  parameter int REG_W         = 16,
  parameter int OP_W          = 8,
  parameter int DISP_W        = 8,
  parameter int TAG_W         = 16,
  parameter int PHYS_NARROW   = 20,
  parameter int PHYS_WIDE     = 24,
  parameter int COST_A        = 13,
  parameter int COST_B_NARROW = 14,
  parameter int COST_B_ODD    = 13,
  parameter int COST_B_EVEN   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode_b,
  input  logic              cfg_wide_bus,
  input  logic              cfg_phys24,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [OP_W-1:0]   ins_op0,
  input  logic [OP_W-1:0]   ins_op1,
  input  logic [DISP_W-1:0] ins_disp,
  output logic [1:0]        ptr_sel,
  input  logic [PTR_W-1:0]  ptr_data,
  output logic [1:0]        src_sel,
  input  logic [REG_W-1:0]  src_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [REG_W-1:0]  wr_data,
  output logic [1:0]        wr_be,
  output logic              wr_logical,
  output logic              done,
  output logic              illegal
);
  localparam int MAX_AB   = (COST_A > COST_B_NARROW) ? COST_A : COST_B_NARROW;
  localparam int MAX_OE   = (COST_B_ODD > COST_B_EVEN) ? COST_B_ODD : COST_B_EVEN;
  localparam int COST_MAX = (MAX_AB > MAX_OE) ? MAX_AB : MAX_OE;
  localparam int CNT_W    = $clog2(COST_MAX + 1);

  src_reg_e         src_e;
  logic             legal, accept, start, busy, wide_eff, single;
  logic             illegal_q;
  agen_t            ag;
  logic [CNT_W-1:0] cost;

  psu_decode #(.OP_W(OP_W)) u_dec (
    .op0(ins_op0), .op1(ins_op1), .ptr_sel(ptr_sel), .src_sel(src_e), .legal(legal)
  );

  assign src_sel = src_e;

  psu_agen #(
    .PTR_W(PTR_W), .DISP_W(DISP_W), .TAG_W(TAG_W),
    .PHYS_NARROW(PHYS_NARROW), .PHYS_WIDE(PHYS_WIDE)
  ) u_agen (
    .ptr(ptr_data), .disp(ins_disp), .phys24(cfg_phys24), .res(ag)
  );

  // R6/R7/R8: bus shape and budget chosen at acceptance
  always_comb begin
    ins_ready = !busy;
    accept    = ins_valid && ins_ready;
    start     = accept && legal;
    wide_eff  = cfg_mode_b && cfg_wide_bus;
    single    = wide_eff && !ag.odd;
    if (!cfg_mode_b)   cost = CNT_W'(COST_A);
    else if (!wide_eff) cost = CNT_W'(COST_B_NARROW);
    else if (ag.odd)   cost = CNT_W'(COST_B_ODD);
    else               cost = CNT_W'(COST_B_EVEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= accept && !legal;   // R9
  end
  assign illegal = illegal_q;

  psu_wr_seq #(.PTR_W(PTR_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .addr_lo(ag.addr_lo), .addr_hi(ag.addr_hi), .logical(ag.logical),
    .single(single), .src(src_data), .cost(cost), .busy(busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_logical(wr_logical), .done(done)
  );

  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_valid && !done && ins_ready));

  p_phys_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_logical) |-> (wr_addr[PTR_W-1:PHYS_WIDE] == '0));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ins_ready);
endmodule

// File: tb/ptr_store_unit_test.sv
module ptr_store_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mode_b = 1'b0, cfg_wide_bus = 1'b0, cfg_phys24 = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [7:0]  ins_op0 = '0, ins_op1 = '0, ins_disp = '0;
  logic [1:0]  ptr_sel, src_sel;
  logic [31:0] ptr_data;
  logic [15:0] src_data;
  logic        wr_valid, wr_ready = 1'b1, wr_logical, done, illegal;
  logic [31:0] wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  wr_be;

  int checks = 0, errors = 0, cyc = 0, stall_until = 0;
  logic [31:0] ptrs [4] = '{32'h0000_1000, 32'hFFFF_FFF0, 32'h0012_3457, 32'hFFFF_FFFF};
  logic [15:0] regs [4] = '{16'h1122, 16'h3344, 16'h5566, 16'h7788};

  typedef struct { logic [31:0] a; logic [15:0] d; logic [1:0] be; logic lg; } wexp_t;
  wexp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign ptr_data = ptrs[ptr_sel];
  assign src_data = regs[src_sel];

  initial forever begin
    @(posedge clk); #1;
    wr_ready = (cyc >= stall_until);
  end

  ptr_store_unit uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (q.size() == 0) chk(0, "R9", "unexpected write addr", wr_addr, 0);
      else begin
        wexp_t e;
        e = q.pop_front();
        chk(wr_addr == e.a, "R2", "write address", wr_addr, e.a);
        chk(wr_data == e.d, "R3", "write data", wr_data, e.d);
        chk(wr_be == e.be, "R6", "byte enables", wr_be, e.be);
        chk(wr_logical == e.lg, "R4", "logical flag", wr_logical, e.lg);
      end
    end
  end

  task automatic push(input logic [31:0] a, input logic [15:0] d,
                      input logic [1:0] be, input logic lg);
    wexp_t e;
    e.a = a; e.d = d; e.be = be; e.lg = lg;
    q.push_back(e);
  endtask

  task automatic send(input logic [7:0] o0, input logic [7:0] o1, input logic [7:0] dp,
                      input bit mb, input bit wd, input bit p24, input int stall_rel,
                      input bit exp_ill, input int cost, input int nbeats, input string req);
    int acc, exp_done, st, n;
    @(negedge clk);
    stall_until = (stall_rel > 0) ? 32'h7fff_ffff : 0;
    @(posedge clk); #1;
    cfg_mode_b = mb; cfg_wide_bus = wd; cfg_phys24 = p24;
    ins_op0 = o0; ins_op1 = o1; ins_disp = dp; ins_valid = 1'b1;
    @(negedge clk);
    chk(ins_ready == 1'b1, "R10", "ready while idle", ins_ready, 1);
    chk(ptr_sel == o1[5:4], "R1", "pointer select", ptr_sel, o1[5:4]);
    chk(src_sel == o1[7:6], "R1", "source select", src_sel, o1[7:6]);
    @(posedge clk); #1;
    ins_valid = 1'b0;
    @(negedge clk);
    acc = cyc;
    if (stall_rel > 0) stall_until = acc + stall_rel;
    if (exp_ill) begin
      chk(illegal == 1'b1, "R9", "illegal pulse", illegal, 1);
      chk(done == 1'b0 && wr_valid == 1'b0, "R9", "no activity", {done, wr_valid}, 0);
      chk(ins_ready == 1'b1, "R9", "stays ready", ins_ready, 1);
      @(negedge clk);
      chk(illegal == 1'b0, "R9", "illegal one cycle", illegal, 0);
    end else begin
      chk(ins_ready == 1'b0, "R10", "busy after accept", ins_ready, 0);
      st = (stall_until > acc) ? stall_until : acc;
      exp_done = acc + cost - 1;
      if (st + nbeats - 1 > exp_done) exp_done = st + nbeats - 1;
      n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      chk(cyc == exp_done, (stall_rel > 0) ? "R11" : "R8", "done cycle", cyc, exp_done);
      @(negedge clk);
      chk(done == 1'b0, "R10", "done one cycle", done, 0);
      chk(ins_ready == 1'b1, "R10", "ready after done", ins_ready, 1);
      chk(q.size() == 0, "R7", "all beats issued", q.size(), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R10", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ins_ready == 1'b1 && wr_valid == 1'b0 && done == 1'b0 && illegal == 1'b0,
        "R10", "reset state", {ins_ready, wr_valid, done, illegal}, 4'b1000);
    @(posedge clk); #1 rst_n = 1'b1;

    // R6: wide even single word, budget 12
    push(32'h0000_1004, 16'h1122, 2'b11, 1'b0);
    send(8'h6D, 8'h01, 8'h04, 1, 1, 0, 0, 0, 12, 1, "R6");
    // R7: wide odd after 32-bit wrap, physical, budget 13
    push(32'h0000_006F, 16'h0044, 2'b01, 1'b0);
    push(32'h0000_0070, 16'h0033, 2'b01, 1'b0);
    send(8'h6D, 8'h51, 8'h7F, 1, 1, 0, 0, 0, 13, 2, "R7");
    // R4: logical at FFFF_FFFF, second beat wraps but stays logical
    push(32'hFFFF_FFFF, 16'h0066, 2'b01, 1'b1);
    push(32'h0000_0000, 16'h0055, 2'b01, 1'b1);
    send(8'h6D, 8'hB1, 8'h00, 1, 1, 0, 0, 0, 13, 2, "R4");
    // R5: narrow bus, negative disp, 20-bit mask, budget 14
    push(32'h0002_33D7, 16'h0088, 2'b01, 1'b0);
    push(32'h0002_33D8, 16'h0077, 2'b01, 1'b0);
    send(8'h6D, 8'hE1, 8'h80, 1, 0, 0, 0, 0, 14, 2, "R5");
    // R5: 24-bit mask
    push(32'h0012_33D7, 16'h0088, 2'b01, 1'b0);
    push(32'h0012_33D8, 16'h0077, 2'b01, 1'b0);
    send(8'h6D, 8'hE1, 8'h80, 1, 0, 1, 0, 0, 14, 2, "R5");
    // R8: mode A ignores wide bus, two bytes, budget 13
    push(32'h0000_1004, 16'h0022, 2'b01, 1'b0);
    push(32'h0000_1005, 16'h0011, 2'b01, 1'b0);
    send(8'h6D, 8'h01, 8'h04, 0, 1, 0, 0, 0, 13, 2, "R8");
    // R9: bad prefix, bad low nibble
    send(8'h6C, 8'h01, 8'h04, 1, 1, 0, 0, 1, 0, 0, "R9");
    send(8'h6D, 8'h02, 8'h04, 1, 1, 0, 0, 1, 0, 0, "R9");
    // R11: stall past budget, done coincides with final handshake
    push(32'h0000_0FFE, 16'h3344, 2'b11, 1'b0);
    send(8'h6D, 8'h41, 8'hFE, 1, 1, 0, 15, 0, 12, 1, "R11");
    // R11: two-beat stall
    push(32'h0000_006F, 16'h0044, 2'b01, 1'b0);
    push(32'h0000_0070, 16'h0033, 2'b01, 1'b0);
    send(8'h6D, 8'h51, 8'h7F, 1, 1, 0, 14, 0, 13, 2, "R11");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule